// File: doc/BRIEF.md
# Up-Counting Timer with One Compare Channel

This block is a general-purpose timer that sits on a simple 32-bit register bus. It has one counter that counts up. The counter advances on a divided clock and returns to zero after it reaches a reload limit. One compare register raises a flag and an interrupt when the counter arrives at its value. Software programs the divider, the limit and the compare value. It starts and stops the counter, and it can force an update event that restarts the count and makes pending divider and limit values take effect.

The counter width is a parameter, 16 or 32 bits. Counter, limit and compare registers keep only that many bits. Software can therefore find the width by writing all ones to the limit register and reading it back. Typical uses are a free-running time base, a periodic tick from the overflow flag, and a one-shot event armed by writing the current count plus a delay into the compare register.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control register (0x00), counter (0x24), divider register (0x28) and status register (0x10) read 0. The limit register (0x2C) reads all ones of the counter width, and `irq` is 0.
- R2: The counter, limit and compare registers hold only the counter width. In a 16-bit build, writing 0xFFFFFFFF to the limit register reads back 0xFFFF, and writing 0x12345 to the counter reads back 0x2345. A 32-bit build keeps all 32 bits.
- R3: With control bit 0 set and an active divider value N, the counter increments once every N+1 clocks. After the tick where it equals the active limit, the next tick takes it to 0.
- R4: A value written to the divider register (16 bits) is used only after the next update event. Until then, counting continues at the previously active ratio.
- R5: Writing 1 to bit 0 of the event register (0x14) is a software update. It clears the counter and the divider phase, loads the pending divider and limit values, and sets status bit 0.
- R6: A counter wrap while control bit 1 is clear is an update event: it sets status bit 0 and loads the pending values. `irq` is high while status bit 0 and enable bit 0 of register 0x0C are both set.
- R7: While control bit 1 is set, a wrap still returns the counter to 0, but it sets no flag and loads no pending value. A software update still loads them.
- R8: Status bit 1 is set in the tick that brings the counter to the compare value (0x34). `irq` is high while it is set and enable bit 1 is set.
- R9: A write to the status register clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged.
- R10: Writing 0 to the enable register drives `irq` low from the next cycle, whatever flags are set.
- R11: With control bit 3 set, control bit 0 clears itself at the first wrap, and the counter then stays at 0.
- R12: With control bit 7 set, the wrap compares against a buffered limit that is loaded only by update events. With bit 7 clear, the written limit applies at once.
- R13: The counter reads its current value while it runs, and a write to it loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational, zero-extended |
| irq | output | 1 | Interrupt: OR of enabled status flags |

## Verification
The bench builds two copies on the same bus: a 16-bit counter (the default) and a 32-bit counter. The pair shows the width-discovery readback and the counter-write truncation side by side.

With the 16-bit copy, small limits and divider ratios from 1 to 5 bring these cases within a few dozen cycles:
- several wraps in one run;
- a pending divider held back across wraps while update events are disabled;
- the one-pulse stop;
- buffered against direct limit behaviour.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int BUS_W = 32;
  localparam int PSC_W = 16;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_IEN  = 'h0C;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_EVT  = 'h14;
  localparam int OFS_CNT  = 'h24;
  localparam int OFS_PSC  = 'h28;
  localparam int OFS_LIM  = 'h2C;
  localparam int OFS_CMP  = 'h34;

  typedef struct packed {
    logic run;
    logic updDis;
    logic arBuf;
    logic swUpd;
    logic cntWr;
  } ctlStb_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrapEvt,
  input  logic              updEvt,
  input  logic              cmpHit,
  output ctlStb_t           stb,
  output logic [PSC_W-1:0]  pscReg,
  output logic [CNT_W-1:0]  limReg,
  output logic [CNT_W-1:0]  cmpReg,
  output logic [1:0]        flags,
  output logic [BUS_W-1:0]  rdData,
  output logic              irq
);
  logic runQ, updDisQ, onePulseQ, arBufQ;
  logic [1:0] ienQ;
  logic wrCtrl, wrIen, wrStat, wrEvt, wrCnt, wrPsc, wrLim, wrCmp;
  logic [BUS_W-1:0] cntRd, limRd, cmpRd;
  logic unusedWr;

  assign unusedWr = ^wrData;

  assign wrCtrl = wrEn && (addr == ADDR_W'(OFS_CTRL));
  assign wrIen  = wrEn && (addr == ADDR_W'(OFS_IEN));
  assign wrStat = wrEn && (addr == ADDR_W'(OFS_STAT));
  assign wrEvt  = wrEn && (addr == ADDR_W'(OFS_EVT));
  assign wrCnt  = wrEn && (addr == ADDR_W'(OFS_CNT));
  assign wrPsc  = wrEn && (addr == ADDR_W'(OFS_PSC));
  assign wrLim  = wrEn && (addr == ADDR_W'(OFS_LIM));
  assign wrCmp  = wrEn && (addr == ADDR_W'(OFS_CMP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runQ      <= 1'b0;
      updDisQ   <= 1'b0;
      onePulseQ <= 1'b0;
      arBufQ    <= 1'b0;
      ienQ      <= 2'b00;
      flags     <= 2'b00;
      pscReg    <= '0;
      limReg    <= '1;
      cmpReg    <= '0;
    end else begin
      if (wrCtrl) begin
        runQ      <= wrData[0];
        updDisQ   <= wrData[1];
        onePulseQ <= wrData[3];
        arBufQ    <= wrData[7];
      end else if (wrapEvt && onePulseQ) begin
        runQ <= 1'b0;
      end
      if (wrIen) ienQ <= wrData[1:0];
      flags <= (wrStat ? (flags & wrData[1:0]) : flags) | {cmpHit, updEvt};
      if (wrPsc) pscReg <= wrData[PSC_W-1:0];
      if (wrLim) limReg <= wrData[CNT_W-1:0];
      if (wrCmp) cmpReg <= wrData[CNT_W-1:0];
    end
  end

  assign stb.run    = runQ;
  assign stb.updDis = updDisQ;
  assign stb.arBuf  = arBufQ;
  assign stb.swUpd  = wrEvt && wrData[0];
  assign stb.cntWr  = wrCnt;

  assign irq = |(flags & ienQ);

  if (CNT_W < BUS_W) begin : gNarrow
    assign cntRd = {{(BUS_W-CNT_W){1'b0}}, cnt};
    assign limRd = {{(BUS_W-CNT_W){1'b0}}, limReg};
    assign cmpRd = {{(BUS_W-CNT_W){1'b0}}, cmpReg};
  end else begin : gFull
    assign cntRd = cnt;
    assign limRd = limReg;
    assign cmpRd = cmpReg;
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFS_CTRL): rdData = {24'd0, arBufQ, 3'd0, onePulseQ, 1'b0, updDisQ, runQ};
      ADDR_W'(OFS_IEN):  rdData = {30'd0, ienQ};
      ADDR_W'(OFS_STAT): rdData = {30'd0, flags};
      ADDR_W'(OFS_CNT):  rdData = cntRd;
      ADDR_W'(OFS_PSC):  rdData = {{(BUS_W-PSC_W){1'b0}}, pscReg};
      ADDR_W'(OFS_LIM):  rdData = limRd;
      ADDR_W'(OFS_CMP):  rdData = cmpRd;
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStb_t          stb,
  input  logic [PSC_W-1:0] pscReg,
  input  logic [CNT_W-1:0] limReg,
  input  logic [CNT_W-1:0] cmpReg,
  input  logic [CNT_W-1:0] cntWrVal,
  output logic [CNT_W-1:0] cnt,
  output logic [PSC_W-1:0] pscActive,
  output logic             wrapEvt,
  output logic             updEvt,
  output logic             cmpHit
);
  logic [PSC_W-1:0] divCnt;
  logic [CNT_W-1:0] limShadow, limEff, nextCnt;
  logic tick;

  assign limEff  = stb.arBuf ? limShadow : limReg;
  assign tick    = stb.run && (divCnt == pscActive);
  assign wrapEvt = tick && (cnt == limEff);
  assign updEvt  = stb.swUpd || (wrapEvt && !stb.updDis);
  assign nextCnt = wrapEvt ? '0 : cnt + 1'b1;
  assign cmpHit  = tick && !stb.swUpd && !stb.cntWr && (nextCnt == cmpReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt    <= '0;
      pscActive <= '0;
      limShadow <= '1;
      cnt       <= '0;
    end else begin
      if (updEvt) begin
        pscActive <= pscReg;
        limShadow <= limReg;
      end
      if (stb.swUpd || tick) divCnt <= '0;
      else if (stb.run)      divCnt <= divCnt + 1'b1;
      if (stb.swUpd)      cnt <= '0;
      else if (stb.cntWr) cnt <= cntWrVal;
      else if (tick)      cnt <= nextCnt;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irq
);
  ctlStb_t          ctlStb;
  logic [PSC_W-1:0] pscReg, pscActive;
  logic [CNT_W-1:0] limReg, cmpReg, cnt;
  logic [1:0]       flags;
  logic             wrapEvt, updEvt, cmpHit;

  tick_timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .cnt(cnt), .wrapEvt(wrapEvt), .updEvt(updEvt), .cmpHit(cmpHit),
    .stb(ctlStb), .pscReg(pscReg), .limReg(limReg), .cmpReg(cmpReg),
    .flags(flags), .rdData(rdData), .irq(irq)
  );

  tick_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(ctlStb), .pscReg(pscReg),
    .limReg(limReg), .cmpReg(cmpReg), .cntWrVal(wrData[CNT_W-1:0]),
    .cnt(cnt), .pscActive(pscActive), .wrapEvt(wrapEvt),
    .updEvt(updEvt), .cmpHit(cmpHit)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wrData,
  input logic              irq,
  input logic              run,
  input logic              updDis,
  input logic              swUpd,
  input logic              cntWr,
  input logic [CNT_W-1:0]  cnt,
  input logic [PSC_W-1:0]  pscActive,
  input logic              wrapEvt,
  input logic              updEvt,
  input logic [1:0]        flags
);
  logic onePulseSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) onePulseSeen <= 1'b0;
    else if (wrEn && addr == ADDR_W'(OFS_CTRL)) onePulseSeen <= wrData[3];
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cntWr && !swUpd) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));

  // R4
  psc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !updEvt |=> $stable(pscActive));

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapEvt && !updDis) |=> flags[0]);

  // R7
  upd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (updDis && !swUpd && !flags[0]) |=> !flags[0]);

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(OFS_IEN) && wrData[1:0] == 2'b00) |=> !irq);

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (onePulseSeen && run && wrapEvt && !(wrEn && addr == ADDR_W'(OFS_CTRL))) |=> !run);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .irq(irq), .run(ctlStb.run), .updDis(ctlStb.updDis), .swUpd(ctlStb.swUpd),
  .cntWr(ctlStb.cntWr), .cnt(cnt), .pscActive(pscActive),
  .wrapEvt(wrapEvt), .updEvt(updEvt), .flags(flags)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  import tick_timer_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [31:0] wrData = 32'h0;
  logic [31:0] rdData, rdData32;
  logic irq, irq32;
  int nChecks = 0;
  int nFail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(16), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq));

  tick_timer #(.CNT_W(32), .ADDR_W(8)) u1 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData32), .irq(irq32));

  // {divider, limit, extra cycles, expected count}
  localparam logic [63:0] VEC [6] = '{
    {16'd0, 16'd100,  16'd9,  16'd10},
    {16'd1, 16'd100,  16'd9,  16'd5},
    {16'd3, 16'd100,  16'd19, 16'd5},
    {16'd0, 16'd4,    16'd11, 16'd2},
    {16'd2, 16'd3,    16'd23, 16'd0},
    {16'd4, 16'd1000, 16'd49, 16'd10}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 8'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    addr = 8'(a);
    #1;
    v = rdData;
  endtask

  task automatic rdChk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic runFor(input logic [31:0] startCtl, input logic [31:0] stopCtl, input int extra);
    wr(OFS_CTRL, startCtl);
    repeat (extra) @(negedge clk);
    wr(OFS_CTRL, stopCtl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 ctrl", OFS_CTRL, 32'h0);
    rdChk("R1 cnt", OFS_CNT, 32'h0);
    rdChk("R1 psc", OFS_PSC, 32'h0);
    rdChk("R1 stat", OFS_STAT, 32'h0);
    rdChk("R1 limit", OFS_LIM, 32'h0000FFFF);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R2 width discovery and truncation
    wr(OFS_LIM, 32'hFFFFFFFF);
    rdChk("R2 limit 16b", OFS_LIM, 32'h0000FFFF);
    addr = 8'(OFS_LIM); #1;
    check("R2 limit 32b", rdData32, 32'hFFFFFFFF);
    wr(OFS_CNT, 32'h00012345);
    rdChk("R2 R13 cnt write 16b", OFS_CNT, 32'h00002345);
    addr = 8'(OFS_CNT); #1;
    check("R2 cnt write 32b", rdData32, 32'h00012345);

    // R3 vector walk: count rate and wrap
    foreach (VEC[i]) begin
      wr(OFS_CTRL, 32'h0);
      wr(OFS_PSC, {16'd0, VEC[i][63:48]});
      wr(OFS_LIM, {16'd0, VEC[i][47:32]});
      wr(OFS_EVT, 32'h1);
      runFor(32'h1, 32'h0, int'(VEC[i][31:16]));
      rdChk($sformatf("R3 vector %0d", i), OFS_CNT, {16'd0, VEC[i][15:0]});
    end

    // R4 divider shadow
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LIM, 32'd1000);
    wr(OFS_PSC, 32'd0);
    wr(OFS_EVT, 32'h1);
    wr(OFS_PSC, 32'd3);
    rdChk("R4 psc readback", OFS_PSC, 32'd3);
    runFor(32'h1, 32'h0, 9);
    rdChk("R4 old ratio kept", OFS_CNT, 32'd10);
    wr(OFS_EVT, 32'h1);
    runFor(32'h1, 32'h0, 9);
    rdChk("R4 new ratio after update", OFS_CNT, 32'd2);

    // R6 overflow flag and irq
    wr(OFS_LIM, 32'd4);
    wr(OFS_PSC, 32'd0);
    wr(OFS_CMP, 32'h0FFF);
    wr(OFS_EVT, 32'h1);
    wr(OFS_STAT, 32'h0);
    wr(OFS_IEN, 32'h1);
    runFor(32'h1, 32'h0, 3);
    rdChk("R6 cnt before wrap", OFS_CNT, 32'd4);
    rdChk("R6 no flag before wrap", OFS_STAT, 32'h0);
    check("R6 irq low", {31'd0, irq}, 32'h0);
    runFor(32'h1, 32'h0, 0);
    rdChk("R6 R3 wrapped", OFS_CNT, 32'd0);
    rdChk("R6 flag", OFS_STAT, 32'h1);
    check("R6 irq high", {31'd0, irq}, 32'h1);
    wr(OFS_IEN, 32'h0);
    check("R10 irq masked", {31'd0, irq}, 32'h0);
    rdChk("R10 flag kept", OFS_STAT, 32'h1);
    wr(OFS_STAT, 32'h0);
    rdChk("R9 flag cleared", OFS_STAT, 32'h0);

    // R7 update disable; R5 software update
    wr(OFS_CTRL, 32'h2);
    wr(OFS_EVT, 32'h1);
    rdChk("R5 sw update flag", OFS_STAT, 32'h1);
    rdChk("R5 sw update cnt", OFS_CNT, 32'h0);
    wr(OFS_STAT, 32'h0);
    wr(OFS_PSC, 32'd2);
    runFor(32'h3, 32'h2, 5);
    rdChk("R7 wrap without reload", OFS_CNT, 32'd1);
    rdChk("R7 no flag", OFS_STAT, 32'h0);
    wr(OFS_EVT, 32'h1);
    rdChk("R7 R5 sw update flag", OFS_STAT, 32'h1);
    runFor(32'h3, 32'h2, 5);
    rdChk("R7 R5 sw update loaded", OFS_CNT, 32'd2);

    // R8 compare
    wr(OFS_CTRL, 32'h0);
    wr(OFS_PSC, 32'd0);
    wr(OFS_LIM, 32'd1000);
    wr(OFS_EVT, 32'h1);
    wr(OFS_STAT, 32'h0);
    wr(OFS_IEN, 32'h2);
    wr(OFS_CMP, 32'd5);
    runFor(32'h1, 32'h0, 3);
    rdChk("R8 before match", OFS_STAT, 32'h0);
    check("R8 irq low", {31'd0, irq}, 32'h0);
    runFor(32'h1, 32'h0, 0);
    rdChk("R8 cnt at match", OFS_CNT, 32'd5);
    rdChk("R8 flag", OFS_STAT, 32'h2);
    check("R8 irq high", {31'd0, irq}, 32'h1);
    wr(OFS_STAT, 32'h2);
    rdChk("R9 written one keeps", OFS_STAT, 32'h2);
    wr(OFS_STAT, 32'h1);
    rdChk("R9 written zero clears", OFS_STAT, 32'h0);
    check("R9 irq low", {31'd0, irq}, 32'h0);

    // R11 one-pulse; R13 read while running
    wr(OFS_IEN, 32'h0);
    wr(OFS_LIM, 32'd3);
    wr(OFS_EVT, 32'h1);
    wr(OFS_CTRL, 32'h9);
    @(negedge clk);
    rdChk("R13 read while running", OFS_CNT, 32'd1);
    repeat (8) @(negedge clk);
    rdChk("R11 enable cleared", OFS_CTRL, 32'h8);
    rdChk("R11 cnt stopped", OFS_CNT, 32'd0);

    // R12 buffered limit
    wr(OFS_CTRL, 32'h0);
    wr(OFS_LIM, 32'd1000);
    wr(OFS_EVT, 32'h1);
    wr(OFS_LIM, 32'd2);
    runFor(32'h81, 32'h80, 9);
    rdChk("R12 buffered limit", OFS_CNT, 32'd10);
    wr(OFS_CTRL, 32'h0);
    wr(OFS_EVT, 32'h1);
    runFor(32'h1, 32'h0, 9);
    rdChk("R12 direct limit", OFS_CNT, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule